// File: doc/BRIEF.md
# Receive Character Buffer with Selectable Read-Port Polarity

This block is a synchronous first-in first-out store of 256 characters, each 14 bits wide, that sits between a receive controller and a host. The controller pushes characters through a simple write strobe. The host takes them out through a pipelined handshake. It first addresses the block by driving the active-low select line. In the next clock it asserts the read enable. Only a read that follows this sequence removes a character.

A run-time mode input picks the signalling convention of the read port. In one setting the read enable and the full, half-full and empty flags are active low. In the other setting they are all active high. The flags are registered on the rising clock edge and describe the occupancy left after that edge's write and read. Two output-enable signals are also registered. One gates the data bus and is raised only for a read that has been properly addressed. The other gates the flags and follows the select line sampled at the previous edge. A single clock drives both sides, and reset is synchronous.

Top module: `rx_char_buffer`

## Requirements
- R1: Characters are returned in the order they were written. The store holds up to 256 characters of 14 bits each.
- R2: When `act_hi_mode` is 0, `rd_en_pin`, `full_pin`, `half_pin` and `empty_pin` are active low (0 means asserted). When `act_hi_mode` is 1, they are all active high (1 means asserted).
- R3: A read takes place at rising edge k+1 only under two conditions: `sel_n` was sampled 0 at edge k, and `rd_en_pin` is sampled asserted at edge k+1. That edge loads the character into `rd_data` and raises `data_oe` for exactly one cycle. Every other combination leaves `data_oe` at 0 and the occupancy unchanged.
- R4: After each rising edge, `flag_oe` equals 1 when `sel_n` was sampled 0 at that edge, and 0 when it was sampled 1.
- R5: After each edge, the flags reflect the occupancy resulting from that edge. Empty is asserted at 0 entries, full at 256 entries, and half-full at 128 or more entries.
- R6: An addressed read while the store is empty is ignored. `data_oe` stays 0, `rd_data` is unchanged and no character is consumed.
- R7: A write while the store is full is dropped. The stored contents and the occupancy stay unchanged.
- R8: A read and a write at the same edge, with neither blocked, leave the occupancy unchanged.
- R9: Synchronous reset empties the store and clears `data_oe`, `flag_oe` and `rd_data`. It also drives the flags to the empty state in the selected polarity.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Single clock for both sides |
| rst | input | 1 | Synchronous reset, active high |
| act_hi_mode | input | 1 | 0: active-low read port; 1: active-high read port |
| wr_en | input | 1 | Write strobe from the receive controller |
| wr_data | input | 14 | Character to store |
| sel_n | input | 1 | Active-low select, sampled one cycle ahead of the read |
| rd_en_pin | input | 1 | Read enable, polarity set by mode |
| rd_data | output | 14 | Registered output character |
| data_oe | output | 1 | Data bus output enable, one cycle per addressed read |
| flag_oe | output | 1 | Flag output enable, follows sampled select |
| full_pin | output | 1 | Full flag, polarity set by mode |
| half_pin | output | 1 | Half-full flag, polarity set by mode |
| empty_pin | output | 1 | Empty flag, polarity set by mode |

## Verification
The assertions assume three things about the inputs. `act_hi_mode` changes only while reset is held. `sel_n`, `rd_en_pin`, `wr_en` and `wr_data` carry known values at every sampled edge. The first clock after power-up falls inside reset. The bench respects these assumptions: it changes the mode only inside its reset task, it drives every input to a defined idle level from time zero, and it updates inputs only on falling edges. The select-then-read timing checks rely on `sel_n` being stable across each rising edge, which the falling-edge driving guarantees.

// File: rtl/rxb_pkg.sv
package rxb_pkg;
  // Map an internal active-high event onto the port convention.
  function automatic logic to_pin(input logic act_hi, input logic v);
    return act_hi ? v : ~v;
  endfunction

  // Map a port level back onto an internal active-high event.
  function automatic logic from_pin(input logic act_hi, input logic p);
    return act_hi ? p : ~p;
  endfunction
endpackage

// File: rtl/rxb_store.sv
module rxb_store #(
  parameter int DW = 14,
  parameter int DEPTH = 256,
  localparam int AW = $clog2(DEPTH)
) (
  input  logic          clk,
  input  logic          rst,
  input  logic          wr_go,
  input  logic [DW-1:0] wr_data,
  input  logic          rd_go,
  output logic [DW-1:0] rd_data
);
  logic [DW-1:0] mem [DEPTH];
  logic [AW-1:0] wptr_q, rptr_q;

  always_ff @(posedge clk) begin
    if (wr_go) mem[wptr_q] <= wr_data;
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      wptr_q  <= '0;
      rptr_q  <= '0;
      rd_data <= '0;
    end else begin
      if (wr_go) wptr_q <= wptr_q + 1'b1;
      if (rd_go) begin
        rd_data <= mem[rptr_q];
        rptr_q  <= rptr_q + 1'b1;
      end
    end
  end

  // R6: read pointer and output data only move on an accepted read
  assert_rptr_hold_R6: assert property (@(posedge clk) disable iff (rst)
    !rd_go |=> ($stable(rptr_q) && $stable(rd_data)));
  // R7: write pointer only moves on an accepted write
  assert_wptr_hold_R7: assert property (@(posedge clk) disable iff (rst)
    !wr_go |=> $stable(wptr_q));
endmodule

// File: rtl/rxb_status.sv
module rxb_status #(
  parameter int DEPTH = 256,
  localparam int CW = $clog2(DEPTH) + 1,
  localparam int HALF = DEPTH / 2
) (
  input  logic clk,
  input  logic rst,
  input  logic wr_req,
  input  logic rd_req,
  output logic wr_go,
  output logic rd_go,
  output logic full_q,
  output logic half_q,
  output logic empty_q
);
  logic [CW-1:0] cnt_q, cnt_nxt;
  logic is_full, is_empty;

  function automatic logic [CW-1:0] next_occ(input logic [CW-1:0] c,
                                             input logic w, input logic r);
    case ({w, r})
      2'b10:   return c + 1'b1;
      2'b01:   return c - 1'b1;
      default: return c;
    endcase
  endfunction

  assign is_full  = (cnt_q == CW'(DEPTH));
  assign is_empty = (cnt_q == '0);
  assign wr_go    = wr_req & ~is_full;
  assign rd_go    = rd_req & ~is_empty;
  assign cnt_nxt  = next_occ(cnt_q, wr_go, rd_go);

  always_ff @(posedge clk) begin
    if (rst) begin
      cnt_q   <= '0;
      full_q  <= 1'b0;
      half_q  <= 1'b0;
      empty_q <= 1'b1;
    end else begin
      cnt_q   <= cnt_nxt;
      full_q  <= (cnt_nxt == CW'(DEPTH));
      half_q  <= (cnt_nxt >= CW'(HALF));
      empty_q <= (cnt_nxt == '0);
    end
  end

  // R5: occupancy never exceeds capacity
  assert_no_overflow_R5: assert property (@(posedge clk) disable iff (rst)
    cnt_q <= CW'(DEPTH));
  // R8: balanced traffic keeps occupancy
  assert_balanced_R8: assert property (@(posedge clk) disable iff (rst)
    (wr_go && rd_go) |=> $stable(cnt_q));
  // R7: full with no read stays full
  assert_full_drop_R7: assert property (@(posedge clk) disable iff (rst)
    (full_q && !rd_req) |=> full_q);
  // R6: empty with no write stays empty
  assert_empty_read_R6: assert property (@(posedge clk) disable iff (rst)
    (empty_q && !wr_req) |=> empty_q);
  // R5: flags are mutually consistent
  assert_flag_mix_R5: assert property (@(posedge clk) disable iff (rst)
    !(empty_q && (half_q || full_q)) && (!full_q || half_q));
endmodule

// File: rtl/rxb_port.sv
module rxb_port
  import rxb_pkg::*;
(
  input  logic clk,
  input  logic rst,
  input  logic act_hi_mode,
  input  logic sel_n,
  input  logic rd_en_pin,
  input  logic rd_go,
  input  logic full_q,
  input  logic half_q,
  input  logic empty_q,
  output logic rd_req,
  output logic data_oe,
  output logic flag_oe,
  output logic full_pin,
  output logic half_pin,
  output logic empty_pin
);
  logic addr_q;

  assign rd_req = addr_q & from_pin(act_hi_mode, rd_en_pin);

  always_ff @(posedge clk) begin
    if (rst) begin
      addr_q  <= 1'b0;
      data_oe <= 1'b0;
      flag_oe <= 1'b0;
    end else begin
      addr_q  <= ~sel_n;
      data_oe <= rd_go;
      flag_oe <= ~sel_n;
    end
  end

  assign full_pin  = to_pin(act_hi_mode, full_q);
  assign half_pin  = to_pin(act_hi_mode, half_q);
  assign empty_pin = to_pin(act_hi_mode, empty_q);

  // R3: data bus enabled only two cycles after an address phase
  assert_doe_addressed_R3: assert property (@(posedge clk) disable iff (rst)
    data_oe |-> ($past(sel_n, 2) == 1'b0));
  // R3: data bus enable lasts a single cycle per read
  assert_doe_pulse_R3: assert property (@(posedge clk) disable iff (rst)
    (data_oe && !rd_go) |=> !data_oe);
  // R4: flag enable follows the sampled select
  assert_foe_low_R4: assert property (@(posedge clk) disable iff (rst)
    flag_oe |-> !$past(sel_n));
  assert_foe_high_R4: assert property (@(posedge clk) disable iff (rst)
    (!$past(rst) && !$past(sel_n)) |-> flag_oe);
endmodule

// File: rtl/rx_char_buffer.sv
module rx_char_buffer #(
  parameter int DW = 14,
  parameter int DEPTH = 256
) (
  input  logic          clk,
  input  logic          rst,
  input  logic          act_hi_mode,
  input  logic          wr_en,
  input  logic [DW-1:0] wr_data,
  input  logic          sel_n,
  input  logic          rd_en_pin,
  output logic [DW-1:0] rd_data,
  output logic          data_oe,
  output logic          flag_oe,
  output logic          full_pin,
  output logic          half_pin,
  output logic          empty_pin
);
  logic rd_req, rd_go, wr_go;
  logic full_q, half_q, empty_q;

  rxb_port u_port (
    .clk(clk), .rst(rst), .act_hi_mode(act_hi_mode),
    .sel_n(sel_n), .rd_en_pin(rd_en_pin), .rd_go(rd_go),
    .full_q(full_q), .half_q(half_q), .empty_q(empty_q),
    .rd_req(rd_req), .data_oe(data_oe), .flag_oe(flag_oe),
    .full_pin(full_pin), .half_pin(half_pin), .empty_pin(empty_pin)
  );

  rxb_status #(.DEPTH(DEPTH)) u_status (
    .clk(clk), .rst(rst), .wr_req(wr_en), .rd_req(rd_req),
    .wr_go(wr_go), .rd_go(rd_go),
    .full_q(full_q), .half_q(half_q), .empty_q(empty_q)
  );

  rxb_store #(.DW(DW), .DEPTH(DEPTH)) u_store (
    .clk(clk), .rst(rst), .wr_go(wr_go), .wr_data(wr_data),
    .rd_go(rd_go), .rd_data(rd_data)
  );

  // R2: mode selects complementary pin levels for the same state
  assert_pin_polarity_R2: assert property (@(posedge clk) disable iff (rst)
    (empty_pin == (act_hi_mode ? empty_q : !empty_q)) &&
    (full_pin  == (act_hi_mode ? full_q  : !full_q)));
endmodule

// File: tb/rx_char_buffer_tb_top.sv
module rx_char_buffer_tb_top;
  localparam int DW = 14;
  localparam int DEPTH = 256;

  logic clk = 1'b0;
  logic rst = 1'b1;
  logic act_hi_mode = 1'b0;
  logic wr_en = 1'b0;
  logic [DW-1:0] wr_data = '0;
  logic sel_n = 1'b1;
  logic rd_en_pin = 1'b1;
  logic [DW-1:0] rd_data;
  logic data_oe, flag_oe, full_pin, half_pin, empty_pin;

  int n_chk = 0;
  int n_fail = 0;
  bit done = 1'b0;

  always #5 clk = ~clk;

  rx_char_buffer #(.DW(DW), .DEPTH(DEPTH)) dut_i (
    .clk(clk), .rst(rst), .act_hi_mode(act_hi_mode),
    .wr_en(wr_en), .wr_data(wr_data), .sel_n(sel_n), .rd_en_pin(rd_en_pin),
    .rd_data(rd_data), .data_oe(data_oe), .flag_oe(flag_oe),
    .full_pin(full_pin), .half_pin(half_pin), .empty_pin(empty_pin)
  );

  function automatic logic lvl(input logic asserted);
    return act_hi_mode ? asserted : ~asserted;
  endfunction

  function automatic logic [DW-1:0] pat(input int i);
    return DW'((i * 37 + 5) % (1 << DW));
  endfunction

  task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
    n_chk++;
    if (act !== exp) begin
      n_fail++;
      $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
    end
  endtask

  task automatic chk_flags(input string req, input logic f, input logic h, input logic e);
    chk({req, " full"},  32'(full_pin),  32'(lvl(f)));
    chk({req, " half"},  32'(half_pin),  32'(lvl(h)));
    chk({req, " empty"}, 32'(empty_pin), 32'(lvl(e)));
  endtask

  task automatic do_reset(input logic mode);
    @(negedge clk);
    rst = 1'b1; act_hi_mode = mode; wr_en = 1'b0; sel_n = 1'b1;
    rd_en_pin = ~mode;
    repeat (2) @(negedge clk);
    rst = 1'b0;
  endtask

  task automatic push(input logic [DW-1:0] v);
    @(negedge clk);
    wr_en = 1'b1; wr_data = v;
    @(negedge clk);
    wr_en = 1'b0;
  endtask

  task automatic pop(output logic [DW-1:0] d, output logic oe,
                     output logic foe_mid, output logic foe_after);
    @(negedge clk);
    sel_n = 1'b0; rd_en_pin = lvl(1'b0);
    @(negedge clk);
    foe_mid = flag_oe;
    sel_n = 1'b1; rd_en_pin = lvl(1'b1);
    @(negedge clk);
    d = rd_data; oe = data_oe; foe_after = flag_oe;
    rd_en_pin = lvl(1'b0);
  endtask

  // R9 R2: reset state in both conventions
  task automatic t_reset();
    for (int m = 0; m < 2; m++) begin
      do_reset(m[0]);
      chk("R9 data_oe", 32'(data_oe), 0);
      chk("R9 flag_oe", 32'(flag_oe), 0);
      chk("R9 rd_data", 32'(rd_data), 0);
      chk_flags(m == 0 ? "R9 R2 lowmode" : "R9 R2 highmode", 1'b0, 1'b0, 1'b1);
    end
  endtask

  // R6 R3 R4 R1: empty read ignored, then a single character round trip
  task automatic t_empty_then_one();
    logic [DW-1:0] d; logic oe, fm, fa;
    do_reset(1'b0);
    pop(d, oe, fm, fa);
    chk("R6 empty read oe", 32'(oe), 0);
    chk("R6 empty read data", 32'(d), 0);
    chk("R4 flag_oe after select", 32'(fm), 1);
    chk("R4 flag_oe after deselect", 32'(fa), 0);
    push(14'h2AB);
    chk_flags("R5 one entry", 1'b0, 1'b0, 1'b0);
    pop(d, oe, fm, fa);
    chk("R3 addressed read oe", 32'(oe), 1);
    chk("R1 read data", 32'(d), 32'h2AB);
    chk_flags("R5 empty again", 1'b0, 1'b0, 1'b1);
    @(negedge clk);
    chk("R3 oe single cycle", 32'(data_oe), 0);
  endtask

  // R3: reads without proper address phase have no effect
  task automatic t_unaddressed();
    logic [DW-1:0] d; logic oe, fm, fa;
    do_reset(1'b1);
    push(14'h155);
    @(negedge clk);
    sel_n = 1'b1; rd_en_pin = lvl(1'b1);
    repeat (3) begin
      @(negedge clk);
      chk("R3 no select oe", 32'(data_oe), 0);
    end
    rd_en_pin = lvl(1'b0);
    @(negedge clk);
    sel_n = 1'b0; rd_en_pin = lvl(1'b1);
    @(negedge clk);
    sel_n = 1'b1; rd_en_pin = lvl(1'b0);
    chk("R3 same-cycle select oe", 32'(data_oe), 0);
    @(negedge clk);
    chk("R3 late enable missing oe", 32'(data_oe), 0);
    chk_flags("R3 still holding", 1'b0, 1'b0, 1'b0);
    pop(d, oe, fm, fa);
    chk("R3 proper read oe", 32'(oe), 1);
    chk("R1 held data", 32'(d), 32'h155);
  endtask

  // R5 R7 R1: fill to thresholds, overfill, drain in order
  task automatic t_fill_drain(input logic mode);
    logic [DW-1:0] d; logic oe, fm, fa;
    do_reset(mode);
    for (int i = 0; i < DEPTH / 2 - 1; i++) push(pat(i));
    chk_flags("R5 below half", 1'b0, 1'b0, 1'b0);
    push(pat(DEPTH / 2 - 1));
    chk_flags("R5 at half", 1'b0, 1'b1, 1'b0);
    for (int i = DEPTH / 2; i < DEPTH; i++) push(pat(i));
    chk_flags("R5 full", 1'b1, 1'b1, 1'b0);
    push(14'h3FFF);
    chk_flags("R7 write when full", 1'b1, 1'b1, 1'b0);
    for (int i = 0; i < DEPTH; i++) begin
      pop(d, oe, fm, fa);
      if (i == 0 || i == DEPTH - 1 || d !== pat(i) || oe !== 1'b1) begin
        chk("R1 drain data", 32'(d), 32'(pat(i)));
        chk("R3 drain oe", 32'(oe), 1);
      end
      if (i == 0) chk_flags("R5 leaves full", 1'b0, 1'b1, 1'b0);
    end
    chk_flags("R7 dropped write absent", 1'b0, 1'b0, 1'b1);
    pop(d, oe, fm, fa);
    chk("R7 nothing extra", 32'(oe), 0);
  endtask

  // R8: streaming read and write at the half boundary
  task automatic t_balanced();
    logic [DW-1:0] d; logic oe, fm, fa;
    do_reset(1'b0);
    for (int i = 0; i < DEPTH / 2; i++) push(pat(i));
    @(negedge clk);
    sel_n = 1'b0;
    @(negedge clk);
    rd_en_pin = lvl(1'b1); wr_en = 1'b1; wr_data = pat(DEPTH / 2);
    for (int i = 0; i < 4; i++) begin
      @(negedge clk);
      chk("R8 stream oe", 32'(data_oe), 1);
      chk("R8 stream data", 32'(rd_data), 32'(pat(i)));
      chk_flags("R8 occupancy kept", 1'b0, 1'b1, 1'b0);
      wr_data = pat(DEPTH / 2 + i + 1);
      if (i == 3) begin
        wr_en = 1'b0; sel_n = 1'b1; rd_en_pin = lvl(1'b0);
      end
    end
    pop(d, oe, fm, fa);
    chk("R8 next data", 32'(d), 32'(pat(4)));
    chk_flags("R8 one below half", 1'b0, 1'b0, 1'b0);
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    if (!done) begin
      n_chk++; n_fail++;
      $display("FAIL watchdog actual=timeout expected=completion");
      $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
      $finish;
    end
  end

  initial begin
    t_reset();
    t_empty_then_one();
    t_unaddressed();
    t_fill_drain(1'b1);
    t_fill_drain(1'b0);
    t_balanced();
    done = 1'b1;
    $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
    $finish;
  end
endmodule